// File: doc/BRIEF.md
# Multi-Master Memory Crossbar with Per-Slave Round-Robin Arbitration

This block joins six bus masters to five memory slaves through a simplified AHB-Lite style crossbar. The masters are a CPU port (index 0), two general DMA ports (1 and 2), a network DMA (3), a display-refresh DMA (4) and a graphics DMA (5). The slaves are a tightly coupled data RAM reached through the CPU's slave port (slave 0), two on-chip SRAM banks (1 and 2), flash (3) and an external-memory window (4). Each slave carries a small word-wide memory model with byte lanes. Every slave has its own round-robin arbiter, so masters that target different slaves proceed in the same cycle.

A master presents a transfer with `m_valid` and holds it, together with its address, direction, size and write data, until `m_ready` is high for one cycle. A master that loses arbitration simply sees no `m_ready` yet. An address decoder in front of each master also applies a reachability table. An address that matches no slave, lies in the instruction TCM range, names a slave the master may not reach, or is a write from the display master goes to a per-master error responder instead of a slave.

Top module: `mm_xbar`

## Requirements
- R1: A transfer granted at a clock edge completes with `m_ready` high for exactly the following cycle and `m_err` low. A read returns the whole stored 32-bit word at word index addr[7:2] of the slave's memory.
- R2: Masters that request the same slave in the same cycle are served in round-robin order. The next winner is the first requester at or after a pointer, counting upwards and wrapping from 5 to 0. After reset the pointer is 0, and after each completed transfer it becomes winner+1 (mod 6). The slave serves one transfer every two cycles, so the k-th master served (k=1,2,…) from a set that arrived together completes in cycle 2k-1 after presentation. The other masters are stalled without `m_ready` until then.
- R3: Transfers to different slaves do not wait for one another. Each completes in cycle 1 after presentation when it is alone on its slave.
- R4: Byte lanes are little-endian. `m_size` 0 writes the byte lane addr[1:0], 1 writes the two lanes 2*addr[1] and 2*addr[1]+1, and 2 writes all four. Lane n is `m_wdata[8n+7:8n]`. The other lanes keep their value.
- R5: An address in no slave window, including the instruction TCM range 0x0000_0000–0x0000_3FFF, gets a two-cycle error. `m_err` is high in cycles 1 and 2, `m_ready` is low in cycle 1 and high in cycle 2, and no memory changes.
- R6: The CPU master (0) cannot reach the data TCM slave and gets the R5 error response there. The DMA-class masters 1, 2, 3, 4 and 5 reach it normally.
- R7: A write from the display master (4) gets the R5 error response and leaves memory unchanged. Reads from that master complete normally.
- R8: The slave windows are: data TCM 0x2000_0000–0x2001_FFFF, SRAM bank 1 0x2002_0000–0x2007_BFFF, SRAM bank 2 0x2007_C000–0x2007_FFFF, flash 0x0800_0000–0x081F_FFFF, external 0x6000_0000–0x6FFF_FFFF.
- R9: While reset is applied and in the first cycle after it, every `m_ready` and `m_err` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| m_valid | input | 6 | Per-master transfer request, held until `m_ready` |
| m_write | input | 6 | Per-master direction, 1 = write |
| m_size | input | 6x2 | Per-master size: 0 byte, 1 half-word, 2 word |
| m_addr | input | 6x32 | Per-master byte address |
| m_wdata | input | 6x32 | Per-master write data on natural byte lanes |
| m_ready | output | 6 | Per-master transfer completion |
| m_err | output | 6 | Per-master error response |
| m_rdata | output | 6x32 | Per-master read data, valid with `m_ready` |

## Verification
A transfer that wins arbitration returns in cycle 1 after it is presented. The k-th master in a contended set returns in cycle 2k-1, and a rejected route raises `m_err` in cycle 1 and `m_ready` in cycle 2. The bench presents each batch of transfers at a falling edge and then samples every falling edge, counting cycles from 1. It records the cycle of each master's first `m_err` and of its `m_ready`. The expected cycle comes from a bench model of the round-robin pointers and must match exactly, so both stalls and early grants are caught.

// File: rtl/mm_xbar_pkg.sv
// Shared constants, address map and byte-lane helper for the crossbar.
// Assumes 32-bit addresses and data; slave indices are fixed by the map.
package mm_xbar_pkg;
    localparam int NUM_M    = 6;
    localparam int NUM_S    = 5;
    localparam int ADDR_W   = 32;
    localparam int DATA_W   = 32;
    localparam int SEL_W    = $clog2(NUM_S + 1);

    // Slave indices; SEL_NONE marks "no slave / error responder".
    localparam logic [SEL_W-1:0] SEL_DTCM  = 3'd0;
    localparam logic [SEL_W-1:0] SEL_BANK1 = 3'd1;
    localparam logic [SEL_W-1:0] SEL_BANK2 = 3'd2;
    localparam logic [SEL_W-1:0] SEL_FLASH = 3'd3;
    localparam logic [SEL_W-1:0] SEL_EXT   = 3'd4;
    localparam logic [SEL_W-1:0] SEL_NONE  = 3'd5;

    // Reachability: bit [m][s] set when master m may reach slave s.
    localparam logic [NUM_M-1:0][NUM_S-1:0] REACH = {
        5'b11111, 5'b11111, 5'b11111, 5'b11111, 5'b11111, 5'b11110};
    // Masters that may only read.
    localparam logic [NUM_M-1:0] READ_ONLY = 6'b010000;

    // Map a byte address onto a slave index.
    function automatic logic [SEL_W-1:0] addr_to_slave(input logic [ADDR_W-1:0] a);
        if (a >= 32'h2000_0000 && a <= 32'h2001_FFFF) return SEL_DTCM;
        if (a >= 32'h2002_0000 && a <= 32'h2007_BFFF) return SEL_BANK1;
        if (a >= 32'h2007_C000 && a <= 32'h2007_FFFF) return SEL_BANK2;
        if (a >= 32'h0800_0000 && a <= 32'h081F_FFFF) return SEL_FLASH;
        if (a >= 32'h6000_0000 && a <= 32'h6FFF_FFFF) return SEL_EXT;
        return SEL_NONE;
    endfunction

    // Little-endian byte-lane enables for a size code and address offset.
    function automatic logic [DATA_W/8-1:0] lane_mask(input logic [1:0] sz,
                                                       input logic [1:0] off);
        case (sz)
            2'd0:    return 4'b0001 << off;
            2'd1:    return off[1] ? 4'b1100 : 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction
endpackage

// File: rtl/mm_xbar_decode.sv
// Per-master route decoder: picks the target slave and rejects routes the
// master may not take (unmapped, unreachable, or a write by a read-only master).
module mm_xbar_decode
    import mm_xbar_pkg::*;
#(
    parameter int MIDX = 0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              write,
    output logic [SEL_W-1:0]  target,
    output logic              reject
);
    logic [SEL_W-1:0] hit;

    // Decode the window, then apply the per-master route rules.
    always_comb begin
        hit    = addr_to_slave(addr);
        target = hit;
        reject = 1'b0;
        if (hit == SEL_NONE)                       reject = 1'b1;
        else if (!REACH[MIDX][hit])                reject = 1'b1;
        if (READ_ONLY[MIDX] && write)              reject = 1'b1;
    end
endmodule

// File: rtl/mm_xbar_rr_arb.sv
// Round-robin arbiter for one slave. Grants only while the slave is idle;
// the pointer moves to winner+1 when the winner's data phase completes.
module mm_xbar_rr_arb #(
    parameter int N = 6,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    input  logic          busy,
    input  logic          done,
    input  logic [IW-1:0] done_idx,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] gnt_idx
);
    logic [IW-1:0] ptr;

    // Search cyclically from the pointer for the first requester.
    always_comb begin
        gnt     = '0;
        gnt_idx = '0;
        for (int k = 0; k < N; k++) begin
            int idx;
            idx = (int'(ptr) + k) % N;
            if (!busy && gnt == '0 && req[idx]) begin
                gnt[idx] = 1'b1;
                gnt_idx  = IW'(idx);
            end
        end
    end

    // Advance the pointer past the master whose transfer just finished.
    always_ff @(posedge clk) begin
        if (!rst_n)       ptr <= '0;
        else if (done)    ptr <= (int'(done_idx) == N - 1) ? '0 : done_idx + 1'b1;
    end

    p_gnt_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));
    p_idle_serves_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && |req) |-> (gnt != '0));
endmodule

// File: rtl/mm_xbar_mem.sv
// Word-wide memory model for one slave with little-endian byte-lane writes
// and a registered read port. Contents are not reset.
module mm_xbar_mem #(
    parameter int WORDS = 64,
    parameter int DW    = 32,
    localparam int XW   = $clog2(WORDS),
    localparam int BL   = DW / 8
) (
    input  logic          clk,
    input  logic          en,
    input  logic          we,
    input  logic [BL-1:0] lanes,
    input  logic [XW-1:0] idx,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] store [WORDS];

    // Perform the access of a granted address phase.
    always_ff @(posedge clk) begin
        if (en) begin
            for (int b = 0; b < BL; b++)
                if (we && lanes[b]) store[idx][8*b +: 8] <= wdata[8*b +: 8];
            rdata <= store[idx];
        end
    end
endmodule

// File: rtl/mm_xbar.sv
// Crossbar top: per-master decode and error responders, per-slave arbiter,
// data-phase owner register and memory model. A granted transfer occupies
// its slave for one data-phase cycle; rejected routes get a two-cycle error.
module mm_xbar
    import mm_xbar_pkg::*;
#(
    parameter int NM        = NUM_M,
    parameter int NS        = NUM_S,
    parameter int MEM_WORDS = 64,
    localparam int MW       = $clog2(NM),
    localparam int XW       = $clog2(MEM_WORDS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NM-1:0]              m_valid,
    input  logic [NM-1:0]              m_write,
    input  logic [NM-1:0][1:0]         m_size,
    input  logic [NM-1:0][ADDR_W-1:0]  m_addr,
    input  logic [NM-1:0][DATA_W-1:0]  m_wdata,
    output logic [NM-1:0]              m_ready,
    output logic [NM-1:0]              m_err,
    output logic [NM-1:0][DATA_W-1:0]  m_rdata
);
    logic [NM-1:0][SEL_W-1:0] tgt;
    logic [NM-1:0]            bad, pend, err_a, err_b, start_ok, start_err;
    logic [NS-1:0][NM-1:0]    sreq, sgnt;
    logic [NS-1:0][MW-1:0]    gidx, owner;
    logic [NS-1:0]            busy;
    logic [NS-1:0][DATA_W-1:0] srd;

    for (genvar m = 0; m < NM; m++) begin : g_m
        mm_xbar_decode #(.MIDX(m)) u_dec (
            .addr(m_addr[m]), .write(m_write[m]), .target(tgt[m]), .reject(bad[m]));

        // Collect this master's grant from whichever slave gave one.
        always_comb begin
            start_ok[m] = 1'b0;
            for (int s = 0; s < NS; s++) start_ok[m] |= sgnt[s][m];
        end
        assign start_err[m] = m_valid[m] && !pend[m] && bad[m];

        // Track an outstanding transfer and run the two-phase error reply.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend[m]  <= 1'b0;
                err_a[m] <= 1'b0;
                err_b[m] <= 1'b0;
            end else begin
                if (start_ok[m] || start_err[m]) pend[m] <= 1'b1;
                else if (m_ready[m])             pend[m] <= 1'b0;
                err_a[m] <= start_err[m];
                err_b[m] <= err_a[m];
            end
        end

        // Route completion and read data back from the owning slave.
        always_comb begin
            m_ready[m] = err_b[m];
            m_rdata[m] = '0;
            for (int s = 0; s < NS; s++)
                if (busy[s] && owner[s] == MW'(m)) begin
                    m_ready[m] = 1'b1;
                    m_rdata[m] = srd[s];
                end
        end
        assign m_err[m] = err_a[m] | err_b[m];

        p_err_two_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (m_err[m] && !m_ready[m]) |=> (m_err[m] && m_ready[m]));
        p_ok_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (m_ready[m] && !m_err[m]) |=> !m_ready[m]);
        p_ro_nowrite_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (READ_ONLY[m] && m_valid[m] && m_write[m]) |-> !start_ok[m]);
    end

    for (genvar s = 0; s < NS; s++) begin : g_s
        // Requests from masters whose legal route points at this slave.
        always_comb
            for (int m = 0; m < NM; m++)
                sreq[s][m] = m_valid[m] && !pend[m] && !bad[m] && tgt[m] == SEL_W'(s);

        mm_xbar_rr_arb #(.N(NM)) u_arb (
            .clk(clk), .rst_n(rst_n), .req(sreq[s]), .busy(busy[s]),
            .done(busy[s]), .done_idx(owner[s]), .gnt(sgnt[s]), .gnt_idx(gidx[s]));

        // Hold the data-phase owner for the one cycle after a grant.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                busy[s]  <= 1'b0;
                owner[s] <= '0;
            end else begin
                busy[s]  <= |sgnt[s];
                if (|sgnt[s]) owner[s] <= gidx[s];
            end
        end

        mm_xbar_mem #(.WORDS(MEM_WORDS), .DW(DATA_W)) u_mem (
            .clk(clk), .en(|sgnt[s]), .we(m_write[gidx[s]]),
            .lanes(lane_mask(m_size[gidx[s]], m_addr[gidx[s]][1:0])),
            .idx(m_addr[gidx[s]][XW+1:2]), .wdata(m_wdata[gidx[s]]), .rdata(srd[s]));

        p_dphase_one_r1: assert property (@(posedge clk) disable iff (!rst_n)
            busy[s] |=> !busy[s]);
    end
endmodule

// File: tb/sim_mm_xbar.sv
// Bench: directed and seeded random batches; expected cycles, data and errors
// come from a bench model of the address map, rules and round-robin pointers.
module sim_mm_xbar;
    localparam int NM = 6, NS = 5, W = 64;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n;
    logic [NM-1:0] m_valid, m_write, m_ready, m_err;
    logic [NM-1:0][1:0]  m_size;
    logic [NM-1:0][31:0] m_addr, m_wdata, m_rdata;

    mm_xbar u0 (.clk(clk), .rst_n(rst_n), .m_valid(m_valid), .m_write(m_write),
        .m_size(m_size), .m_addr(m_addr), .m_wdata(m_wdata), .m_ready(m_ready),
        .m_err(m_err), .m_rdata(m_rdata));

    int checks = 0, fails = 0;
    logic [31:0] mir [NS][W];
    int ptr [NS];
    bit b_en [NM];
    int r_cyc [NM], r_errc [NM], e_cyc [NM];
    logic [31:0] r_rd [NM];
    bit r_er [NM];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Address map of R8.
    function automatic int dec(input logic [31:0] a);
        if (a >= 32'h2000_0000 && a <= 32'h2001_FFFF) return 0;
        if (a >= 32'h2002_0000 && a <= 32'h2007_BFFF) return 1;
        if (a >= 32'h2007_C000 && a <= 32'h2007_FFFF) return 2;
        if (a >= 32'h0800_0000 && a <= 32'h081F_FFFF) return 3;
        if (a >= 32'h6000_0000 && a <= 32'h6FFF_FFFF) return 4;
        return -1;
    endfunction

    // Route rules of R5, R6, R7; -1 means error response.
    function automatic int route(input int m, input logic [31:0] a, input bit w);
        int s;
        s = dec(a);
        if (s < 0) return -1;
        if (m == 0 && s == 0) return -1;
        if (m == 4 && w) return -1;
        return s;
    endfunction

    function automatic string why(input int m, input logic [31:0] a);
        if (dec(a) < 0) return "R5";
        if (m == 0 && dec(a) == 0) return "R6";
        return "R7";
    endfunction

    function automatic logic [3:0] lanes(input logic [1:0] sz, input logic [1:0] off);
        if (sz == 0) return 4'b0001 << off;
        if (sz == 1) return off[1] ? 4'b1100 : 4'b0011;
        return 4'b1111;
    endfunction

    // Present one batch and record when each master sees err and ready.
    task automatic run_batch();
        int c;
        @(negedge clk);
        for (int m = 0; m < NM; m++) begin
            m_valid[m] = b_en[m];
            r_cyc[m] = -1; r_errc[m] = -1; r_er[m] = 0; r_rd[m] = '0;
        end
        c = 0;
        while (m_valid != '0 && c < 40) begin
            @(negedge clk);
            c++;
            for (int m = 0; m < NM; m++)
                if (m_valid[m]) begin
                    if (m_err[m] && r_errc[m] < 0) r_errc[m] = c;
                    if (m_ready[m]) begin
                        r_cyc[m] = c; r_rd[m] = m_rdata[m]; r_er[m] = m_err[m];
                        m_valid[m] = 1'b0;
                    end
                end
        end
        m_valid = '0;
    endtask

    // Compare a finished batch against the model, then commit writes.
    task automatic check_batch();
        int cnt [NS];
        for (int s = 0; s < NS; s++) begin
            bit left [NM];
            int k;
            cnt[s] = 0;
            for (int m = 0; m < NM; m++) begin
                left[m] = b_en[m] && route(m, m_addr[m], m_write[m]) == s;
                if (left[m]) cnt[s]++;
            end
            k = 0;
            while (k < cnt[s]) begin
                for (int j = 0; j < NM; j++) begin
                    int m;
                    m = (ptr[s] + j) % NM;
                    if (left[m]) begin
                        left[m] = 0; e_cyc[m] = 2 * k + 1; k++;
                        ptr[s] = (m + 1) % NM;
                        break;
                    end
                end
            end
        end
        for (int m = 0; m < NM; m++) begin
            int s;
            if (!b_en[m]) continue;
            s = route(m, m_addr[m], m_write[m]);
            if (s < 0) begin
                chk(r_errc[m] == 1, why(m, m_addr[m]), "err first cycle", r_errc[m], 1);
                chk(r_cyc[m] == 2 && r_er[m], why(m, m_addr[m]), "err ready cycle", r_cyc[m], 2);
            end else begin
                chk(r_cyc[m] == e_cyc[m], cnt[s] > 1 ? "R2" : "R3", "ready cycle",
                    r_cyc[m], e_cyc[m]);
                chk(!r_er[m], "R1", "unexpected err", r_er[m], 0);
                if (!m_write[m])
                    chk(r_rd[m] === mir[s][m_addr[m][7:2]], "R1", "read data",
                        r_rd[m], mir[s][m_addr[m][7:2]]);
            end
        end
        for (int m = 0; m < NM; m++) begin
            int s;
            if (!b_en[m] || !m_write[m]) continue;
            s = route(m, m_addr[m], m_write[m]);
            if (s < 0) continue;
            for (int b = 0; b < 4; b++)
                if (lanes(m_size[m], m_addr[m][1:0])[b])
                    mir[s][m_addr[m][7:2]][8*b +: 8] = m_wdata[m][8*b +: 8];
        end
    endtask

    task automatic setm(input int m, input logic [31:0] a, input bit w,
                        input logic [1:0] sz, input logic [31:0] d);
        b_en[m] = 1; m_addr[m] = a; m_write[m] = w; m_size[m] = sz; m_wdata[m] = d;
    endtask

    task automatic clear_batch();
        for (int m = 0; m < NM; m++) b_en[m] = 0;
    endtask

    task automatic go();
        run_batch();
        check_batch();
        clear_batch();
    endtask

    logic [31:0] base [7];
    bit done = 0;

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        base[0] = 32'h2000_0000; base[1] = 32'h2002_0000; base[2] = 32'h2007_C000;
        base[3] = 32'h0800_0000; base[4] = 32'h6000_0000;
        base[5] = 32'h0000_0000; base[6] = 32'h3000_0000;
        for (int s = 0; s < NS; s++) ptr[s] = 0;
        m_valid = '0; m_write = '0; m_size = '0; m_addr = '0; m_wdata = '0;
        clear_batch();
        rst_n = 0;
        repeat (3) @(negedge clk);
        chk(m_ready == '0 && m_err == '0, "R9", "outputs in reset", {m_ready, m_err}, 0);
        rst_n = 1;
        @(negedge clk);
        chk(m_ready == '0 && m_err == '0, "R9", "outputs after reset", {m_ready, m_err}, 0);

        // Fill all memories; five masters on five slaves at once (R3).
        for (int i = 0; i < W; i++) begin
            setm(1, 32'h2000_0000 + 4 * i, 1, 2, $urandom);
            setm(0, 32'h2002_0000 + 4 * i, 1, 2, $urandom);
            setm(2, 32'h2007_C000 + 4 * i, 1, 2, $urandom);
            setm(3, 32'h0800_0000 + 4 * i, 1, 2, $urandom);
            setm(5, 32'h6000_0000 + 4 * i, 1, 2, $urandom);
            go();
        end

        // R4: little-endian byte and half-word lanes.
        setm(0, 32'h2002_0014, 1, 2, 32'h4433_2211); go();
        setm(0, 32'h2002_0016, 1, 0, 32'h00AA_0000); go();
        setm(0, 32'h2002_0014, 0, 2, 0); go();
        chk(r_rd[0] == 32'h44AA_2211, "R4", "byte lane 2", r_rd[0], 32'h44AA_2211);
        setm(0, 32'h2002_0014, 1, 1, 32'h0000_BEEF); go();
        setm(0, 32'h2002_0014, 0, 2, 0); go();
        chk(r_rd[0] == 32'h44AA_BEEF, "R4", "low half", r_rd[0], 32'h44AA_BEEF);

        // R2: contention rounds on bank 1.
        setm(1, 32'h2002_0040, 0, 2, 0); setm(2, 32'h2002_0044, 0, 2, 0);
        setm(3, 32'h2002_0048, 0, 2, 0); go();
        setm(0, 32'h2002_0050, 0, 2, 0); setm(1, 32'h2002_0054, 0, 2, 0);
        setm(5, 32'h2002_0058, 0, 2, 0); go();
        chk(r_cyc[5] == 1 || ptr[1] != 2, "R2", "wrap order winner", r_cyc[5], 1);

        // R5: instruction TCM and unmapped; R6: CPU vs DMA on data TCM.
        setm(0, 32'h0000_0100, 0, 2, 0); setm(1, 32'h3000_0000, 1, 2, 0); go();
        setm(0, 32'h2000_0008, 0, 2, 0); setm(1, 32'h2000_000C, 0, 2, 0); go();

        // R7: display write rejected, memory checked by another master; read OK.
        setm(4, 32'h2007_C00C, 1, 2, 32'hDEAD_BEEF); go();
        setm(1, 32'h2007_C00C, 0, 2, 0); setm(4, 32'h2007_C010, 0, 2, 0); go();

        // Seeded random batches; each master keeps to its own words.
        for (int n = 0; n < 300; n++) begin
            for (int m = 0; m < NM; m++)
                if ($urandom % 3 != 0) begin
                    int r;
                    r = $urandom % 7;
                    setm(m, base[r] + {24'd0, 3'(m), 3'($urandom), 2'($urandom)},
                         1'($urandom), 2'($urandom % 3), $urandom);
                end
            go();
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule